// File: doc/BRIEF.md
# Pin-Level General-Purpose I/O Port

This block controls a bank of general-purpose pins through a small memory-mapped register port. Software writes an output-value word and a drive-enable word and reads back a synchronized image of the pin levels. Both control words can be written whole. They can also be changed one bit at a time through write-1-to-set and write-1-to-clear aliases. The alias writes need no read-modify-write sequence, so two agents that own different pins cannot overwrite each other's bits.

Each request on the register port lasts one cycle and is marked by `req_valid`. The port has no ready signal and accepts a request in every cycle, so there is no back-pressure. A read returns one registered response in the following cycle. The pin drivers take their values straight from the two control words: a drive-enable bit of 1 turns that pin into an output. To get the level of an output pin, software reads the output-value word. To get the level of an input pin, it reads the level word.

Top module: `gpio_regport`

## Requirements
- R1: After reset the output-value word and the drive-enable word are all zero, `pin_oe` and `pin_out` are zero, and `rsp_valid` is low.
- R2: A write to offset 0x00 replaces the whole output-value word. A write to offset 0x08 replaces the whole drive-enable word. The new value appears on the pins one cycle after the request.
- R3: A write to offset 0x40 sets every output-value bit whose write-data bit is 1 and leaves every other bit unchanged.
- R4: A write to offset 0x44 clears every output-value bit whose write-data bit is 1 and leaves every other bit unchanged.
- R5: A write to offset 0x48 sets drive-enable bits and a write to offset 0x4C clears them. Both use the same write-1 rule as R3 and R4.
- R6: `pin_out` always equals the output-value word and `pin_oe` always equals the drive-enable word. A drive-enable bit of 1 makes that pin an output.
- R7: `pin_in` passes through two flip-flops before it reaches the level word at offset 0x04. If a pin changes before clock edge e, a read sampled at edge e+1 still returns the old level, and a read sampled at edge e+2 returns the new level.
- R8: A read request (`req_valid`=1, `req_write`=0) produces `rsp_valid`=1 in the next cycle. `rsp_rdata` then carries the word at that offset as it stood when the request was sampled. In every other cycle `rsp_valid` is 0 and `rsp_rdata` is 0.
- R9: A read of any offset other than 0x00, 0x04, 0x08, 0x40, 0x44, 0x48 or 0x4C returns 0. Reads of the four alias offsets also return 0. A write to an unmapped offset, or to the read-only level word at 0x04, changes neither control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A register request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_rdata | output | 32 | Read data, 0 when rsp_valid is low |
| pin_in | input | 32 | Pin levels, asynchronous to clk |
| pin_out | output | 32 | Output value for each pin |
| pin_oe | output | 32 | Drive enable for each pin, 1 = output |

## Verification
Two things can land on the same clock edge: a register request being decoded, and a new pin level coming out of the synchronizer. A control-word update can also land on the same edge as the response to a read issued just before it. The bench provokes both by changing `pin_in` in the same cycle as a read of the level word, and by placing reads directly behind alias writes. It also issues random request streams while the pins toggle. A cycle-accurate reference model built from the requirements is compared against the response and pin outputs at every clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned OFS_OUT     = 'h00;
  localparam int unsigned OFS_LEVEL   = 'h04;
  localparam int unsigned OFS_DIR     = 'h08;
  localparam int unsigned OFS_OUT_SET = 'h40;
  localparam int unsigned OFS_OUT_CLR = 'h44;
  localparam int unsigned OFS_DIR_SET = 'h48;
  localparam int unsigned OFS_DIR_CLR = 'h4C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OUT,
    SEL_LEVEL,
    SEL_DIR,
    SEL_OUT_SET,
    SEL_OUT_CLR,
    SEL_DIR_SET,
    SEL_DIR_CLR
  } reg_sel_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFS_OUT))          sel = SEL_OUT;
    else if (addr == ADDR_W'(OFS_LEVEL))   sel = SEL_LEVEL;
    else if (addr == ADDR_W'(OFS_DIR))     sel = SEL_DIR;
    else if (addr == ADDR_W'(OFS_OUT_SET)) sel = SEL_OUT_SET;
    else if (addr == ADDR_W'(OFS_OUT_CLR)) sel = SEL_OUT_CLR;
    else if (addr == ADDR_W'(OFS_DIR_SET)) sel = SEL_DIR_SET;
    else if (addr == ADDR_W'(OFS_DIR_CLR)) sel = SEL_DIR_CLR;
  end

endmodule

// File: rtl/gpio_bitreg.sv
// Control word with a whole-word write and per-bit set/clear strobes.
// Priority: whole write, then set, then clear.
module gpio_bitreg #(
  parameter int          W   = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en)       nxt = wdata;
    else if (set_en) nxt = q | wdata;
    else if (clr_en) nxt = q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= nxt;
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_regport.sv
module gpio_regport
  import gpio_pkg::*;
#(
  parameter int W           = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [W-1:0]      req_wdata,
  output logic              rsp_valid,
  output logic [W-1:0]      rsp_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe
);

  reg_sel_e     sel;
  logic         wr, rd;
  logic [W-1:0] out_q, dir_q, level_q;
  logic [W-1:0] rd_mux;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .sel  (sel)
  );

  assign wr = req_valid &&  req_write;
  assign rd = req_valid && !req_write;

  gpio_bitreg #(.W(W), .RST('0)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr && sel == SEL_OUT),
    .set_en (wr && sel == SEL_OUT_SET),
    .clr_en (wr && sel == SEL_OUT_CLR),
    .wdata  (req_wdata),
    .q      (out_q)
  );

  gpio_bitreg #(.W(W), .RST('0)) u_dir (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr && sel == SEL_DIR),
    .set_en (wr && sel == SEL_DIR_SET),
    .clr_en (wr && sel == SEL_DIR_CLR),
    .wdata  (req_wdata),
    .q      (dir_q)
  );

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (level_q)
  );

  always_comb begin
    unique case (sel)
      SEL_OUT:   rd_mux = out_q;
      SEL_LEVEL: rd_mux = level_q;
      SEL_DIR:   rd_mux = dir_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_regport_chk.sv
module gpio_regport_chk #(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [W-1:0]      req_wdata,
  input logic              rsp_valid,
  input logic [W-1:0]      rsp_rdata,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_oe
);

  logic rd_req, wr_req, mapped_rd, dir_touch, out_touch;
  assign rd_req    = req_valid && !req_write;
  assign wr_req    = req_valid &&  req_write;
  assign mapped_rd = req_addr == ADDR_W'('h00) || req_addr == ADDR_W'('h04)
                  || req_addr == ADDR_W'('h08);
  assign dir_touch = wr_req && (req_addr == ADDR_W'('h08) || req_addr == ADDR_W'('h48)
                  || req_addr == ADDR_W'('h4C));
  assign out_touch = wr_req && (req_addr == ADDR_W'('h00) || req_addr == ADDR_W'('h40)
                  || req_addr == ADDR_W'('h44));

  // R1
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_quiet: assert (pin_out == '0 && pin_oe == '0 && !rsp_valid);
  end

  // R2
  a_r2_direct_out: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && req_addr == ADDR_W'('h00) |=> pin_out == $past(req_wdata));

  // R3
  a_r3_set_only_marked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && req_addr == ADDR_W'('h40) |=>
      pin_out == ($past(pin_out) | $past(req_wdata)));

  // R4
  a_r4_clear_only_marked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && req_addr == ADDR_W'('h44) |=>
      pin_out == ($past(pin_out) & ~$past(req_wdata)));

  // R5
  a_r5_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && req_addr == ADDR_W'('h48) |=>
      pin_oe == ($past(pin_oe) | $past(req_wdata)));

  a_r5_dir_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && req_addr == ADDR_W'('h4C) |=>
      pin_oe == ($past(pin_oe) & ~$past(req_wdata)));

  // R9: control words move only on their own offsets
  a_r9_dir_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_touch |=> $stable(pin_oe));

  a_r9_out_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !out_touch |=> $stable(pin_out));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !mapped_rd |=> rsp_rdata == '0);

  // R8
  a_r8_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid && rsp_rdata == '0);

endmodule

bind gpio_regport gpio_regport_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/sim_gpio_regport.sv
`timescale 1ns/1ps
module sim_gpio_regport;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] pin_in = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata, pin_out, pin_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  gpio_regport u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Behavioural reference model, written from the requirements.
  logic [31:0] m_out, m_dir, m_s1, m_s2, m_rdata;
  logic        m_valid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_dir = 0; m_s1 = 0; m_s2 = 0; m_rdata = 0; m_valid = 0;  // R1
    end else begin
      m_valid = req_valid && !req_write;                                   // R8
      m_rdata = 0;
      if (m_valid) begin
        case (req_addr)
          8'h00: m_rdata = m_out;
          8'h04: m_rdata = m_s2;     // R7
          8'h08: m_rdata = m_dir;
          default: m_rdata = 0;      // R9
        endcase
      end
      if (req_valid && req_write) begin
        case (req_addr)
          8'h00: m_out = req_wdata;            // R2
          8'h08: m_dir = req_wdata;            // R2
          8'h40: m_out = m_out | req_wdata;    // R3
          8'h44: m_out = m_out & ~req_wdata;   // R4
          8'h48: m_dir = m_dir | req_wdata;    // R5
          8'h4C: m_dir = m_dir & ~req_wdata;   // R5
          default: ;                           // R9
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      chk("R6 pin_out", pin_out, m_out);
      chk("R6 pin_oe", pin_oe, m_dir);
      chk("R8 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_valid});
      chk("R8 rsp_rdata", rsp_rdata, m_rdata);
    end
  end

  task automatic op(input bit v, input bit w, input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
  endtask

  task automatic idle();
    op(0, 0, 8'h00, 0);
  endtask

  localparam logic [7:0] OFS [12] = '{8'h00, 8'h04, 8'h08, 8'h40, 8'h44, 8'h48,
                                      8'h4C, 8'h0C, 8'h10, 8'h41, 8'hFC, 8'h80};

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: read back all control words after reset
    op(1, 0, 8'h00, 0); op(1, 0, 8'h08, 0); op(1, 0, 8'h04, 0);
    // R2: whole-word writes
    op(1, 1, 8'h00, 32'hA5A5_5A5A); op(1, 0, 8'h00, 0);
    op(1, 1, 8'h08, 32'hFFFF_0000); op(1, 0, 8'h08, 0);
    // R3 / R4: output alias writes, including all-zero masks
    op(1, 1, 8'h40, 32'h0000_000F); op(1, 0, 8'h00, 0);
    op(1, 1, 8'h44, 32'h0000_0005); op(1, 0, 8'h00, 0);
    op(1, 1, 8'h40, 0); op(1, 1, 8'h44, 0); op(1, 0, 8'h00, 0);
    op(1, 1, 8'h44, 32'hFFFF_FFFF); op(1, 1, 8'h40, 32'h8000_0001);
    // R5: direction alias writes
    op(1, 1, 8'h48, 32'h0000_00F0); op(1, 1, 8'h4C, 32'hF000_0010);
    op(1, 0, 8'h08, 0);
    // R9: ignored writes, zero reads
    op(1, 1, 8'h04, 32'hDEAD_BEEF); op(1, 1, 8'h10, 32'hFFFF_FFFF);
    op(1, 1, 8'h41, 32'hFFFF_FFFF); op(1, 1, 8'hFC, 32'hFFFF_FFFF);
    op(1, 0, 8'h40, 0); op(1, 0, 8'h4C, 0); op(1, 0, 8'h41, 0);
    op(1, 0, 8'h00, 0); op(1, 0, 8'h08, 0);
    // R7: pin change with back-to-back reads of the level word
    op(1, 0, 8'h04, 0); pin_in = 32'h1234_5678;
    op(1, 0, 8'h04, 0); op(1, 0, 8'h04, 0); op(1, 0, 8'h04, 0);
    pin_in = 32'hCAFE_0001;
    op(1, 0, 8'h04, 0); op(1, 0, 8'h04, 0); op(1, 0, 8'h04, 0);
    idle();
    // Random request streams with toggling pins (R2..R9)
    for (int i = 0; i < 600; i++) begin
      op($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
         OFS[$urandom_range(0, 11)], $urandom);
      if ($urandom_range(0, 2) == 0) pin_in = $urandom;
    end
    idle(); idle();
    // R1: reset mid-run returns to idle state
    #1 rst_n = 1'b0;
    op(1, 0, 8'h00, 0); idle();
    #1 rst_n = 1'b1;
    op(1, 0, 8'h08, 0); idle(); idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule